// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is a serial slave that gives a host access to a byte-wide register bank spread over a 13-bit address space. The host uses three wires: an active-low chip select, a serial clock and one shared data line. Inside the chip the data line appears as a separate input, output and output enable. The block oversamples all three wires with the system clock. It decodes a 16-bit instruction, then either writes incoming bytes into the bank or reads bytes from it and shifts them out.

Every transaction opens with the instruction word. Bit 15 is the direction flag, where 1 means read. Bits 14:13 give the transfer length, and bits 12:0 give the first byte address. Data bytes follow. After each byte the address steps on its own, and the step direction is tied to the bit order. With MSB-first order (the default) bits arrive high bit first and the address counts down. With LSB-first order bits arrive low bit first and the address counts up. The order comes from the `lsb_first_i` input, which the register bank drives from its active mode bit. The block captures it once, when chip select falls.

FSM states: `ST_IDLE` (chip select high), `ST_INSTR` (collecting the instruction), `ST_WRITE` (collecting write bytes), `ST_READ` (driving read bytes) and `ST_HOLD` (fixed-length transfer finished, waiting for chip select to rise). The transitions are:
- chip select low: `ST_IDLE`→`ST_INSTR`
- 16th instruction bit with the read flag: `ST_INSTR`→`ST_READ`
- 16th instruction bit without the read flag: `ST_INSTR`→`ST_WRITE`
- last byte of a fixed-length transfer: `ST_WRITE`/`ST_READ`→`ST_HOLD`
- chip select high: any state→`ST_IDLE`

Top module: `sercfg_port`

## Requirements
- R1: The instruction is 16 bits wide. Bit 15 = 1 selects a read and 0 a write, bits 14:13 are the length code, and bits 12:0 are the first byte address placed on `reg_addr`.
- R2: Length code 0, 1 and 2 transfer 1, 2 and 3 bytes. Code 3 streams until chip select rises. Bytes clocked after a fixed-length transfer ends cause no write, and no read drive.
- R3: With `lsb_first_i`=0 the instruction and data bits go most significant bit first, and the byte address decrements by one after each data byte.
- R4: With `lsb_first_i`=1 the instruction and data bits go least significant bit first, and the byte address increments by one after each data byte.
- R5: The address wraps modulo 8192: 0x0000 steps down to 0x1FFF, and 0x1FFF steps up to 0x0000. No address is skipped.
- R6: The bit order is captured when chip select falls. A change of `lsb_first_i` during a transaction has no effect until the next one.
- R7: Each complete write byte gives exactly one single-cycle `reg_we` pulse. During the pulse `reg_addr` holds that byte's address and `reg_wdata` holds the byte.
- R8: On a read, `reg_rdata` for the current address is shifted out on `sdio_o`. Each bit changes after a falling serial clock edge and holds through the next rising edge.
- R9: `sdio_oe` is high only during the data phase of a read. It is low during the instruction and on writes. It drops when a fixed-length read ends or when chip select rises.
- R10: Chip select rising at any point ends the transaction. A partial byte is discarded without a write, and the next transaction starts from a fresh instruction.
- R11: After reset `sdio_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Data line output value for reads |
| sdio_oe | output | 1 | Output enable for the data line pad |
| lsb_first_i | input | 1 | Active bit-order mode, 1 = LSB first |
| reg_addr | output | ADDR_W | Register bank byte address |
| reg_wdata | output | DATA_W | Register bank write data |
| reg_we | output | 1 | Register bank write strobe, one cycle per byte |
| reg_rdata | input | DATA_W | Register bank read data for `reg_addr` |

## Verification
Some properties are checked on every cycle:
- the output enable appears only in the read state, and falls once chip select is high
- the write strobe is a single pulse that always follows a cycle in the write state
- the address moves by exactly one after each strobe, in the direction set by the captured order
- a high chip select always returns the machine to idle

Other behaviour only the bench's sweep can show:
- the bit order of the instruction and data
- the values of read and written bytes
- the byte count for each length code
- wrapping at both ends of the address space
- ignoring a mid-transaction order change
- the discarding of a partial byte

The sweep runs each length code, both orders and both directions against start addresses at and near the wrap points.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INSTR = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_HOLD  = 3'd4
    } sercfg_state_e;

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= RST_VAL;
                end else begin
                    if (s == 0) pipe[s] <= d_i;
                    else        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/sercfg_shreg.sv
module sercfg_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         lsb_i,
    input  logic         din_i,
    output logic [W-1:0] word_nx_o
);

    logic [W-1:0] word_q;

    // LSB first fills from the top, MSB first fills from the bottom
    assign word_nx_o = lsb_i ? {din_i, word_q[W-1:1]} : {word_q[W-2:0], din_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (shift_i) word_q <= word_nx_o;
    end

endmodule

// File: rtl/sercfg_addrgen.sv
module sercfg_addrgen #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_i,
    input  logic          down_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val_i;
        end else if (step_i) begin
            // natural wrap modulo 2**AW
            addr_q <= down_i ? addr_q - AW'(1) : addr_q + AW'(1);
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/sercfg_txsel.sv
module sercfg_txsel #(
    parameter int DW = 8,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] byte_i,
    input  logic [IW-1:0] idx_i,
    input  logic          lsb_i,
    output logic          bit_o
);

    always_comb begin
        if (lsb_i) bit_o = byte_i[idx_i];
        else       bit_o = byte_i[IW'(DW-1) - idx_i];
    end

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
    import sercfg_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic              lsb_first_i,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int INSTR_W = 1 + LEN_W + ADDR_W;
    localparam int CNT_W   = $clog2(INSTR_W);
    localparam int DBIT_W  = $clog2(DATA_W);

    sercfg_state_e state, state_nx;

    logic              csn_s, sclk_s, sdi_s, sclk_q;
    logic              cs_act, sclk_rise, sclk_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  byte_cnt, len_q;
    logic              stream_q, lsb_q, step_q;
    logic              sdo_q, oe_q, we_q;
    logic [DATA_W-1:0] wdata_q, tx_byte_q, tx_src;
    logic [INSTR_W-1:0] sh_nx;
    logic              tx_bit;
    logic              instr_last, byte_last, xfer_last;
    logic [DATA_W-1:0] rx_byte;

    // ---------------- input synchronisation ----------------
    sercfg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdio_i, sclk_i, csn_i}),
        .q_o   ({sdi_s, sclk_s, csn_s})
    );

    assign cs_act    = ~csn_s;
    assign sclk_rise =  sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s &  sclk_q;

    // ---------------- shift-in path ----------------
    sercfg_shreg #(.W(INSTR_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (sclk_rise && (state == ST_INSTR || state == ST_WRITE)),
        .lsb_i     (lsb_q),
        .din_i     (sdi_s),
        .word_nx_o (sh_nx)
    );

    assign rx_byte    = lsb_q ? sh_nx[INSTR_W-1 -: DATA_W] : sh_nx[DATA_W-1:0];
    assign instr_last = (bit_cnt == CNT_W'(INSTR_W-1));
    assign byte_last  = (bit_cnt == CNT_W'(DATA_W-1));
    assign xfer_last  = byte_last && !stream_q && (byte_cnt == len_q);

    // ---------------- address generation ----------------
    sercfg_addrgen #(.AW(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state == ST_INSTR && sclk_rise && instr_last),
        .load_val_i (sh_nx[ADDR_W-1:0]),
        .step_i     (step_q),
        .down_i     (~lsb_q),
        .addr_o     (reg_addr)
    );

    // ---------------- read bit selection ----------------
    assign tx_src = (bit_cnt == '0) ? reg_rdata : tx_byte_q;

    sercfg_txsel #(.DW(DATA_W)) u_txsel (
        .byte_i (tx_src),
        .idx_i  (bit_cnt[DBIT_W-1:0]),
        .lsb_i  (lsb_q),
        .bit_o  (tx_bit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        if (!cs_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_INSTR;
                ST_INSTR: if (sclk_rise && instr_last)
                              state_nx = sh_nx[INSTR_W-1] ? ST_READ : ST_WRITE;
                ST_WRITE,
                ST_READ:  if (sclk_rise && xfer_last) state_nx = ST_HOLD;
                ST_HOLD:  state_nx = ST_HOLD;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            len_q     <= '0;
            stream_q  <= 1'b0;
            lsb_q     <= 1'b0;
            step_q    <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            tx_byte_q <= '0;
            sdo_q     <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            we_q   <= 1'b0;
            step_q <= 1'b0;
            if (!cs_act) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
                oe_q     <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        lsb_q    <= lsb_first_i;
                        bit_cnt  <= '0;
                        byte_cnt <= '0;
                    end
                    ST_INSTR: begin
                        if (sclk_rise) begin
                            if (instr_last) begin
                                bit_cnt  <= '0;
                                len_q    <= sh_nx[ADDR_W +: LEN_W];
                                stream_q <= &sh_nx[ADDR_W +: LEN_W];
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (sclk_rise) begin
                            if (byte_last) begin
                                bit_cnt  <= '0;
                                byte_cnt <= byte_cnt + LEN_W'(1);
                                we_q     <= 1'b1;
                                wdata_q  <= rx_byte;
                                step_q   <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_READ: begin
                        if (sclk_fall) begin
                            sdo_q <= tx_bit;
                            oe_q  <= 1'b1;
                            if (bit_cnt == '0) tx_byte_q <= reg_rdata;
                        end
                        if (sclk_rise) begin
                            if (byte_last) begin
                                bit_cnt  <= '0;
                                byte_cnt <= byte_cnt + LEN_W'(1);
                                step_q   <= 1'b1;
                                if (xfer_last) oe_q <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                            end
                        end
                    end
                    ST_HOLD: oe_q <= 1'b0;
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sdio_o    = sdo_q;
    assign sdio_oe   = oe_q;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;

endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input sercfg_state_e     state,
    input logic              cs_act,
    input logic              lsb_q,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              sdio_oe
);

    // R9
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> state == ST_READ);

    // R9
    oe_cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdio_oe);

    // R7
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R7
    we_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(state) == ST_WRITE);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we) |-> reg_addr == (lsb_q ? $past(reg_addr) + ADDR_W'(1)
                                             : $past(reg_addr) - ADDR_W'(1)));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == ST_IDLE);

endmodule

bind sercfg_port sercfg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .cs_act   (cs_act),
    .lsb_q    (lsb_q),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .sdio_oe  (sdio_oe)
);

// File: tb/sim_sercfg_port.sv
`timescale 1ns/1ps
module sim_sercfg_port;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        lsb_mode = 1'b0;
    logic        sdio_o, sdio_oe, reg_we;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    int wn = 0;
    logic [12:0] wa [16];
    logic [7:0]  wd [16];

    always #4 clk = ~clk;

    function automatic logic [7:0] rd_f(input logic [12:0] a);
        return (a[7:0] + 8'(a[12:8]) * 8'd13) ^ 8'h5A;
    endfunction

    function automatic logic [12:0] ea(input int a, input int k, input bit lsb);
        return lsb ? 13'((a + k) & 32'h1FFF) : 13'((a - k) & 32'h1FFF);
    endfunction

    assign reg_rdata = rd_f(reg_addr);

    sercfg_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_i       (csn),
        .sclk_i      (sclk),
        .sdio_i      (sdi),
        .sdio_o      (sdio_o),
        .sdio_oe     (sdio_oe),
        .lsb_first_i (lsb_mode),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata)
    );

    always @(negedge clk) begin
        if (rst_n && reg_we && wn < 16) begin
            wa[wn] = reg_addr;
            wd[wn] = reg_wdata;
            wn = wn + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic bit_cycle(input logic din, output logic dout, output logic oe);
        sdi = din;
        repeat (HALF) @(negedge clk);
        dout = sdio_o;
        oe   = sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // one transaction; flip toggles the mode input after chip select falls
    task automatic xact(input bit rd, input int len, input int addr, input bit lsb,
                        input int nbytes, input int seed, input bit flip);
        logic [15:0] instr;
        logic        dout, oe, b;
        logic [7:0]  data, rbyte;
        int          base, exp_n;
        instr = {rd, 2'(len), 13'(addr)};
        exp_n = (len == 3) ? nbytes : ((nbytes < len + 1) ? nbytes : len + 1);
        @(negedge clk);
        lsb_mode = lsb;
        repeat (2) @(negedge clk);
        csn = 1'b0;
        repeat (4) @(negedge clk);
        if (flip) lsb_mode = ~lsb;
        for (int i = 0; i < 16; i++) begin
            b = lsb ? instr[i] : instr[15-i];
            bit_cycle(b, dout, oe);
            chk("R9 oe low in instruction", int'(oe), 0);
        end
        base = wn;
        for (int k = 0; k < nbytes; k++) begin
            data  = 8'(k * 53 + addr + 17 * seed);
            rbyte = '0;
            for (int j = 0; j < 8; j++) begin
                b = lsb ? data[j] : data[7-j];
                bit_cycle(b, dout, oe);
                if (lsb) rbyte[j] = dout; else rbyte[7-j] = dout;
                if (j == 0 || j == 7)
                    chk("R9 oe in data phase", int'(oe), int'(rd && k < exp_n));
            end
            if (rd && k < exp_n) begin
                if (flip)
                    chk("R6 read byte with order change", int'(rbyte), int'(rd_f(ea(addr, k, lsb))));
                else
                    chk("R8 read byte", int'(rbyte), int'(rd_f(ea(addr, k, lsb))));
            end
        end
        repeat (4) @(negedge clk);
        csn = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 oe released at chip select high", int'(sdio_oe), 0);
        if (!rd) begin
            chk("R2 write byte count", wn - base, exp_n);
            for (int k = 0; k < exp_n && base + k < 16; k++) begin
                data = 8'(k * 53 + addr + 17 * seed);
                if (k == 0)
                    chk("R1 first address", int'(wa[base]), addr);
                else if ((lsb && addr + k > 13'h1FFF) || (!lsb && addr - k < 0))
                    chk("R5 wrapped address", int'(wa[base+k]), int'(ea(addr, k, lsb)));
                else if (lsb)
                    chk("R4 incrementing address", int'(wa[base+k]), int'(ea(addr, k, lsb)));
                else
                    chk("R3 decrementing address", int'(wa[base+k]), int'(ea(addr, k, lsb)));
                if (flip)
                    chk("R6 write data with order change", int'(wd[base+k]), int'(data));
                else
                    chk("R7 write data", int'(wd[base+k]), int'(data));
            end
        end else begin
            chk("R2 no write on read", wn - base, 0);
        end
        if (wn > 12) wn = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int addrs [4];
        logic dout, oe;
        int base;
        logic [15:0] instr;
        addrs = '{0, 13'h1FFF, 13'h0034, 13'h0A5B};
        repeat (5) @(negedge clk);
        chk("R11 oe after reset", int'(sdio_oe), 0);
        chk("R11 we after reset", int'(reg_we), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 oe idle", int'(sdio_oe), 0);

        // sweep: order x direction x length x start address
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 2; r++)
                for (int l = 0; l < 4; l++)
                    for (int a = 0; a < 4; a++)
                        xact(r[0], l, addrs[a], m[0], (l == 3) ? 5 : l + 2, a + l, 1'b0);

        // R6: mode input flipped mid-transaction is ignored
        xact(1'b0, 2, 13'h0101, 1'b0, 3, 7, 1'b1);
        xact(1'b1, 2, 13'h1FFE, 1'b1, 3, 8, 1'b1);

        // R10: abort after one full byte plus four bits
        wn = 0;
        lsb_mode = 1'b0;
        @(negedge clk);
        csn = 1'b0;
        repeat (4) @(negedge clk);
        instr = {1'b0, 2'd2, 13'h0200};
        for (int i = 0; i < 16; i++) bit_cycle(instr[15-i], dout, oe);
        base = wn;
        for (int i = 0; i < 12; i++) bit_cycle(1'b1, dout, oe);
        csn = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 partial byte dropped", wn - base, 1);
        chk("R10 full byte address", int'(wa[base]), 13'h0200);

        // R10: abort inside the instruction, then a clean transaction
        csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 7; i++) bit_cycle(1'b1, dout, oe);
        csn = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 no write after instruction abort", wn - base, 1);
        xact(1'b0, 1, 13'h0777, 1'b1, 2, 3, 1'b0);

        finish_run();
    end

endmodule